// File: doc/BRIEF.md
# Oversampled Serial Word Receiver

This block receives asynchronous serial characters on a single input line. The line is sampled on an oversampling tick that arrives sixteen times per bit period; the tick is produced elsewhere. Once reception is enabled, the block watches for a low start bit and confirms it at mid-bit. It then shifts in eight or nine data bits, least significant bit first, and checks the stop bit. Each bit value is a majority vote over three samples taken around the middle of the bit.

A completed character is copied into a holding register and a ready flag is raised. When a second character completes before software has collected the first, the new one is dropped and an overrun is recorded. Frame errors and noise are reported per character, and a break is reported as a frame error. Software collects a character in two steps: it reads the status, then it reads the data. That pair of reads clears the ready flag and all error flags. An interrupt request follows the ready flag, gated by a local enable and a global mask.

Top module: `serial_word_receiver`

## Requirements
- R1: While `rx_en_i` is low, no start bit is accepted and `ready_o` never rises.
- R2: In 8-bit mode (`nine_bit_i` = 0), the first bit after the start bit lands in `rx_data_o[0]` and the eighth in `rx_data_o[7]`. `rx_bit8_o` reads 0.
- R3: In 9-bit mode (`nine_bit_i` = 1), nine data bits are received before the stop bit. The first eight fill `rx_data_o[0..7]` in order, and the ninth appears on `rx_bit8_o`.
- R4: After reset, `ready_o`, all error flags and `rx_data_o` are 0. When a character completes with `ready_o` low, the character is loaded and `ready_o` goes to 1.
- R5: A one-cycle `stat_rd_i` pulse, taken while `ready_o` or `overrun_err_o` is 1, followed later by a one-cycle `data_rd_i` pulse clears `ready_o`, `frame_err_o`, `noise_err_o` and `overrun_err_o`. A `data_rd_i` pulse without such a preceding status read changes none of them.
- R6: If a character completes while `ready_o` is still 1, `overrun_err_o` goes to 1 and `rx_data_o` keeps the earlier character.
- R7: A stop bit that votes low sets `frame_err_o` together with `ready_o`, and the data bits are still delivered. An all-zero character with a low stop bit (a break) therefore reads as data 0 with `frame_err_o` = 1.
- R8: Each bit is sampled at oversample positions 7, 8 and 9 (counting from 0 at the tick that first sees the start edge). The majority of the three gives the bit value. If the three samples in any bit of a character disagree, `noise_err_o` is set along with that character.
- R9: A start edge whose majority vote at mid-bit is high is treated as a glitch. The receiver returns to idle without delivering a character, and the next valid frame is received normally.
- R10: `irq_o` is 1 exactly when `ready_o` = 1, `rx_irq_en_i` = 1 and `irq_mask_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | Oversampling strobe, sixteen per bit period |
| rx_en_i | input | 1 | Receive enable |
| nine_bit_i | input | 1 | Word length select: 0 = 8 bits, 1 = 9 bits |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks the request |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data read strobe |
| rx_data_o | output | 8 | Received data byte |
| rx_bit8_o | output | 1 | Ninth data bit in 9-bit mode |
| ready_o | output | 1 | Character waiting |
| frame_err_o | output | 1 | Stop bit was low |
| noise_err_o | output | 1 | Sample disagreement in the character |
| overrun_err_o | output | 1 | A character was dropped |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest cases to reach from the ports are sample disagreement inside the three-sample vote, and the false start that follows a break. The disagreement needs a one-tick flip at one exact oversample position, and the false start comes from the tail of a low stop bit. The stimulus aligns every line change to the tick strobe, so each bench position matches one receiver sample position. It flips the line for a single tick at position 8 of a chosen data bit, and it drives a break followed by a return to idle. Overrun and the two-step clear are reached by sending back-to-back characters without reads, and by issuing the reads in the wrong order.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit8;
        logic              frame_err;
        logic              noise;
    } rx_word_t;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic split3(input logic [2:0] v);
        return (v != 3'b000) && (v != 3'b111);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  logic     tick_i,
    input  logic     rx_i,
    input  logic     nine_i,
    output logic     done_o,
    output rx_word_t word_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(OVERSAMPLE / 2 + 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_8  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_9  = IDX_W'(DATA_W);

    rx_state_e          state;
    logic [CNT_W-1:0]   s_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [DATA_W:0]    shreg;
    logic [2:0]         votes;
    logic               noise_acc;
    logic               nine_q;

    logic [2:0]         votes_now;
    logic               bit_val;
    logic               bit_noisy;
    logic               at_vote;
    logic               at_decide;
    logic [IDX_W-1:0]   last_idx;

    always_comb begin
        votes_now = {votes[1:0], rx_i};
        bit_val   = maj3(votes_now);
        bit_noisy = split3(votes_now);
        at_vote   = (s_cnt >= VOTE_A) && (s_cnt <= VOTE_C);
        at_decide = (s_cnt == VOTE_C);
        last_idx  = nine_q ? IDX_9 : IDX_8;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            s_cnt     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            votes     <= '0;
            noise_acc <= 1'b0;
            nine_q    <= 1'b0;
            done_o    <= 1'b0;
            word_o    <= '0;
        end else begin
            done_o <= 1'b0;
            if (!en_i) begin
                state <= ST_IDLE;
            end else if (tick_i) begin
                if (state == ST_IDLE) begin
                    if (!rx_i) begin
                        state     <= ST_START;
                        s_cnt     <= CNT_W'(1);
                        bit_idx   <= '0;
                        noise_acc <= 1'b0;
                        nine_q    <= nine_i;
                    end
                end else begin
                    s_cnt <= (s_cnt == LAST_S) ? '0 : s_cnt + 1'b1;
                    if (at_vote) votes <= votes_now;
                    case (state)
                        ST_START: begin
                            if (at_decide) begin
                                if (bit_val) state <= ST_IDLE;
                                else         noise_acc <= bit_noisy;
                            end
                            if (s_cnt == LAST_S) state <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (at_decide) begin
                                shreg     <= {bit_val, shreg[DATA_W:1]};
                                noise_acc <= noise_acc | bit_noisy;
                            end
                            if (s_cnt == LAST_S) begin
                                if (bit_idx == last_idx) state <= ST_STOP;
                                else                     bit_idx <= bit_idx + 1'b1;
                            end
                        end
                        ST_STOP: begin
                            if (at_decide) begin
                                done_o           <= 1'b1;
                                word_o.data      <= nine_q ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
                                word_o.bit8      <= nine_q & shreg[DATA_W];
                                word_o.frame_err <= ~bit_val;
                                word_o.noise     <= noise_acc | bit_noisy;
                                state            <= ST_IDLE;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  rx_word_t          word_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bit8_o,
    output logic              ready_o,
    output logic              fe_o,
    output logic              nf_o,
    output logic              ovr_o
);
    rx_word_t held;
    logic     ready_q;
    logic     ovr_q;
    logic     armed;
    logic     clear;

    assign clear = data_rd_i & armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (stat_rd_i && (ready_q || ovr_q)) armed <= 1'b1;
            if (clear) begin
                ready_q        <= 1'b0;
                ovr_q          <= 1'b0;
                held.frame_err <= 1'b0;
                held.noise     <= 1'b0;
                armed          <= 1'b0;
            end
            if (done_i) begin
                if (ready_q && !clear) begin
                    ovr_q <= 1'b1;
                end else begin
                    held    <= word_i;
                    ready_q <= 1'b1;
                end
            end
        end
    end

    assign data_o  = held.data;
    assign bit8_o  = held.bit8;
    assign fe_o    = held.frame_err;
    assign nf_o    = held.noise;
    assign ready_o = ready_q;
    assign ovr_o   = ovr_q;
endmodule

// File: rtl/serial_word_receiver.sv
module serial_word_receiver
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              tick16_i,
    input  logic              rx_en_i,
    input  logic              nine_bit_i,
    input  logic              rx_irq_en_i,
    input  logic              irq_mask_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit8_o,
    output logic              ready_o,
    output logic              frame_err_o,
    output logic              noise_err_o,
    output logic              overrun_err_o,
    output logic              irq_o
);
    logic     rx_s;
    logic     done;
    rx_word_t word;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    srx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .en_i   (rx_en_i),
        .tick_i (tick16_i),
        .rx_i   (rx_s),
        .nine_i (nine_bit_i),
        .done_o (done),
        .word_o (word)
    );

    srx_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .word_i    (word),
        .stat_rd_i (stat_rd_i),
        .data_rd_i (data_rd_i),
        .data_o    (rx_data_o),
        .bit8_o    (rx_bit8_o),
        .ready_o   (ready_o),
        .fe_o      (frame_err_o),
        .nf_o      (noise_err_o),
        .ovr_o     (overrun_err_o)
    );

    assign irq_o = ready_o & rx_irq_en_i & ~irq_mask_i;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en_i,
    input logic       rx_irq_en_i,
    input logic       irq_mask_i,
    input logic       data_rd_i,
    input logic [7:0] rx_data_o,
    input logic       ready_o,
    input logic       frame_err_o,
    input logic       noise_err_o,
    input logic       overrun_err_o,
    input logic       irq_o
);
    assert_gate_by_enable_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(rx_en_i, 2));

    assert_clear_needs_data_read_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(data_rd_i));

    assert_overrun_holds_word_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_err_o) |-> ($stable(rx_data_o) && ready_o));

    assert_frame_err_with_word_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err_o) |-> $rose(ready_o));

    assert_noise_with_word_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(noise_err_o) |-> $rose(ready_o));

    assert_irq_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ready_o && rx_irq_en_i && !irq_mask_i));
endmodule

bind serial_word_receiver srx_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_en_i       (rx_en_i),
    .rx_irq_en_i   (rx_irq_en_i),
    .irq_mask_i    (irq_mask_i),
    .data_rd_i     (data_rd_i),
    .rx_data_o     (rx_data_o),
    .ready_o       (ready_o),
    .frame_err_o   (frame_err_o),
    .noise_err_o   (noise_err_o),
    .overrun_err_o (overrun_err_o),
    .irq_o         (irq_o)
);

// File: tb/sim_serial_word_receiver.sv
`timescale 1ns/1ps
module sim_serial_word_receiver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick;
    logic       rx_en = 1'b0;
    logic       nine = 1'b0;
    logic       ie = 1'b1;
    logic       mask = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, ready, fe, nf, ovr, irq;
    logic [1:0] tcnt = 2'd0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // vector: {nine, word[8:0], stop level, glitch in data bit 2}
    localparam logic [11:0] VEC [0:5] = '{
        {1'b0, 9'h0A5, 1'b1, 1'b0},
        {1'b0, 9'h03C, 1'b1, 1'b1},
        {1'b1, 9'h1A5, 1'b1, 1'b0},
        {1'b1, 9'h05A, 1'b1, 1'b1},
        {1'b0, 9'h000, 1'b0, 1'b0},
        {1'b0, 9'h0FF, 1'b0, 1'b0}
    };

    always #5 clk = ~clk;

    always @(posedge clk) tcnt <= rst ? 2'd0 : tcnt + 2'd1;
    assign tick = (tcnt == 2'd3);

    serial_word_receiver u0 (
        .clk           (clk),
        .rst           (rst),
        .rx_i          (rx),
        .tick16_i      (tick),
        .rx_en_i       (rx_en),
        .nine_bit_i    (nine),
        .rx_irq_en_i   (ie),
        .irq_mask_i    (mask),
        .stat_rd_i     (stat_rd),
        .data_rd_i     (data_rd),
        .rx_data_o     (rx_data),
        .rx_bit8_o     (rx_bit8),
        .ready_o       (ready),
        .frame_err_o   (fe),
        .noise_err_o   (nf),
        .overrun_err_o (ovr),
        .irq_o         (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic align();
        do @(negedge clk); while (!tick);
        @(negedge clk);
    endtask

    task automatic hold(input logic v);
        rx = v;
        do @(negedge clk); while (!tick);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic nm, input logic [8:0] w,
                              input logic stop, input logic glitch);
        int nb;
        nine = nm;
        nb = nm ? 9 : 8;
        align();
        for (int t = 0; t < 16; t++) hold(1'b0);
        for (int b = 0; b < nb; b++)
            for (int t = 0; t < 16; t++)
                hold((glitch && b == 2 && t == 8) ? ~w[b] : w[b]);
        for (int t = 0; t < 16; t++) hold(stop);
        for (int t = 0; t < 30; t++) hold(1'b1);
    endtask

    task automatic pulse_stat();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4", "reset ready", ready, 0);
        chk("R4", "reset data", rx_data, 0);
        chk("R4", "reset flags", {fe, nf, ovr}, 0);
        chk("R10", "reset irq", irq, 0);

        // R1: disabled receiver ignores a complete frame
        send_frame(1'b0, 9'h05A, 1'b1, 1'b0);
        chk("R1", "ready while disabled", ready, 0);
        chk("R1", "data while disabled", rx_data, 0);
        rx_en = 1'b1;

        for (int i = 0; i < 6; i++) begin
            logic       vn, vs, vg;
            logic [8:0] vw;
            {vn, vw, vs, vg} = VEC[i];
            send_frame(vn, vw, vs, vg);
            chk(vn ? "R3" : "R2", "data byte", rx_data, vw[7:0]);
            chk(vn ? "R3" : "R2", "ninth bit", rx_bit8, vn ? vw[8] : 1'b0);
            chk("R4", "ready", ready, 1);
            chk("R7", "frame error", fe, !vs);
            chk("R8", "noise", nf, vg);
            chk("R6", "no overrun", ovr, 0);
            chk("R10", "irq", irq, 1);
            pulse_data();
            chk("R5", "data read alone keeps ready", ready, 1);
            chk("R5", "data read alone keeps fe", fe, !vs);
            pulse_stat();
            pulse_data();
            chk("R5", "ready cleared", ready, 0);
            chk("R5", "flags cleared", {fe, nf, ovr}, 0);
        end

        // R6: second word while ready is still set
        send_frame(1'b0, 9'h011, 1'b1, 1'b0);
        send_frame(1'b0, 9'h022, 1'b1, 1'b0);
        chk("R6", "overrun flag", ovr, 1);
        chk("R6", "old word kept", rx_data, 8'h11);
        chk("R6", "ready kept", ready, 1);
        pulse_stat();
        pulse_data();
        chk("R5", "overrun cleared", {ready, ovr}, 0);

        // R9: short low pulse on the line is not a start bit
        nine = 1'b0;
        align();
        for (int t = 0; t < 5; t++) hold(1'b0);
        for (int t = 0; t < 200; t++) hold(1'b1);
        chk("R9", "glitch start rejected", ready, 0);
        send_frame(1'b0, 9'h0C3, 1'b1, 1'b0);
        chk("R9", "frame after glitch", rx_data, 8'hC3);
        chk("R9", "ready after glitch", ready, 1);

        // R10: interrupt gating
        mask = 1'b1;
        @(negedge clk);
        chk("R10", "masked irq", irq, 0);
        mask = 1'b0;
        ie = 1'b0;
        @(negedge clk);
        chk("R10", "disabled irq", irq, 0);
        ie = 1'b1;
        @(negedge clk);
        chk("R10", "enabled irq", irq, 1);
        pulse_stat();
        pulse_data();
        chk("R10", "irq after clear", irq, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule